// File: doc/BRIEF.md
# Glitch-Free Grouped Clock Stopper

This block sits between a clock synthesiser's raw outputs and its output drivers. It switches three groups of clocks off and on without runts: a CPU-rate group, a fixed 66 MHz group and a group of gated PCI-rate clocks. Two active-low stop requests control the groups. The CPU stop request controls both the CPU group and the 66 MHz group. The PCI stop request controls only the gated PCI group. A power-down force input overrides both requests and turns every group off. The raw sources all run synchronously, with their rising edges aligned to the CPU clock. The free-running PCI clock is never gated. It is the control clock of the block.

Each group has its own controller, and each controller is a three-state machine clocked by the free-running PCI clock. In GRP_RUN the group's clocks are enabled. GRP_HALT is entered on a stop request. GRP_OFF is entered on power-down force. The next state is GRP_OFF whenever the synchronised force is high (transition FORCE). Otherwise it is GRP_HALT when the group's request is low (transition STOP) and GRP_RUN when it is high (transition START). These three transitions apply from every state, so leaving GRP_OFF is either a START or a STOP. Reset puts both controllers in GRP_OFF.

Each output bit has an enable latch followed by an AND gate. The latch is open only while its raw source is low. An enable change therefore reaches the output only during a low phase. A stopped output therefore rests low, and a restarted output begins on a source rising edge with a full high phase.

Top module: `grp_clk_stopper`

## Requirements
- R1: While the CPU stop request (cpu_stop_n = 0) is in effect, every bit of cpu_out and c66_out stays low.
- R2: While the PCI stop request (pci_stop_n = 0) is in effect, every bit of pci_out stays low.
- R3: Each request affects only its own groups. cpu_stop_n has no effect on pci_out, and pci_stop_n has no effect on cpu_out or c66_out.
- R4: A request level is sampled on each rising edge of clk_pcif, and the group's controller state changes on that same edge. A gated output follows the new state from the first low phase of its raw source after that edge, so the change completes within one clk_pcif period.
- R5: A gated output is either held low or equal to its raw source. Its enable changes only while the source is low, so a restart begins with a source rising edge and a full-width high phase.
- R6: force_off passes through a two-stage synchroniser clocked by clk_pcif. On the third clk_pcif rising edge after it is raised, both controllers enter GRP_OFF and all gated outputs go low, whatever the request levels. After it is released, each group resumes according to its own request.
- R7: While rst_n = 0, all outputs are low and both controllers are in GRP_OFF. On the first clk_pcif rising edge after release, each controller takes GRP_RUN or GRP_HALT from its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Raw CPU-rate source clock |
| clk_66 | input | 1 | Raw fixed 66 MHz source clock |
| clk_pci | input | 1 | Raw source of the gated PCI clocks |
| clk_pcif | input | 1 | Free-running PCI clock; control clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU and 66 MHz groups |
| pci_stop_n | input | 1 | Active-low stop request for the gated PCI group |
| force_off | input | 1 | Power-down force; asynchronous, active high |
| cpu_out | output | N_CPU | Gated CPU-rate clocks |
| c66_out | output | N_66 | Gated 66 MHz clocks |
| pci_out | output | N_PCI | Gated PCI clocks |

## Verification
The bench drives requests that change between control-clock edges. It compares every output at every half period of the CPU clock, so a stop or start that lands one source cycle early or late shows up as a mismatch. A design whose latch was open during the high phase would clip the CPU clock that is high at the switching edge and leave a runt pulse. Force is raised while both requests are active and released while one is still held. A controller that let a request win over force would keep its group running during power-down. One that forgot the request on leaving GRP_OFF would restart a stopped group. The bench also asserts each request alone, which exposes any crosstalk between the two groups.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        GRP_OFF  = 2'd0,
        GRP_HALT = 2'd1,
        GRP_RUN  = 2'd2
    } grp_state_e;

    localparam int unsigned NUM_CTRL = 2;
    localparam int unsigned CTRL_CPU = 0;
    localparam int unsigned CTRL_PCI = 1;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_grp_fsm.sv
module clkstop_grp_fsm
    import clkstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req_n,
    input  logic       force_sync,
    output grp_state_e state,
    output logic       grp_en
);
    grp_state_e state_q;
    grp_state_e state_d;

    // next-state logic: FORCE, STOP, START transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_OFF, GRP_HALT, GRP_RUN: begin
                if (force_sync) begin
                    state_d = GRP_OFF;
                end else if (!stop_req_n) begin
                    state_d = GRP_HALT;
                end else begin
                    state_d = GRP_RUN;
                end
            end
            default: state_d = GRP_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        grp_en = 1'b0;
        unique case (state_q)
            GRP_RUN:  grp_en = 1'b1;
            GRP_HALT: grp_en = 1'b0;
            GRP_OFF:  grp_en = 1'b0;
            default:  grp_en = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] gclk
);
    logic [WIDTH-1:0] en_lat;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        // transparent only during the low phase of the source
        always_latch begin
            if (!rst_n) begin
                en_lat[gi] = 1'b0;
            end else if (!clk_src) begin
                en_lat[gi] = en;
            end
        end
        assign gclk[gi] = clk_src & en_lat[gi];
    end
endmodule

// File: rtl/grp_clk_stopper.sv
module grp_clk_stopper
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU       = 4,
    parameter int unsigned N_66        = 4,
    parameter int unsigned N_PCI       = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_cpu,
    input  logic             clk_66,
    input  logic             clk_pci,
    input  logic             clk_pcif,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             force_off,
    output logic [N_CPU-1:0] cpu_out,
    output logic [N_66-1:0]  c66_out,
    output logic [N_PCI-1:0] pci_out
);
    logic                force_sync;
    logic [NUM_CTRL-1:0] req_n;
    logic [NUM_CTRL-1:0] ctrl_en;
    grp_state_e          ctrl_state [NUM_CTRL];
    grp_state_e          cpu_state;
    grp_state_e          pci_state;

    assign req_n[CTRL_CPU] = cpu_stop_n;
    assign req_n[CTRL_PCI] = pci_stop_n;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_force_sync (
        .clk     (clk_pcif),
        .rst_n   (rst_n),
        .d_async (force_off),
        .q_sync  (force_sync)
    );

    for (genvar ci = 0; ci < NUM_CTRL; ci++) begin : g_ctrl
        clkstop_grp_fsm u_fsm (
            .clk        (clk_pcif),
            .rst_n      (rst_n),
            .stop_req_n (req_n[ci]),
            .force_sync (force_sync),
            .state      (ctrl_state[ci]),
            .grp_en     (ctrl_en[ci])
        );
    end

    assign cpu_state = ctrl_state[CTRL_CPU];
    assign pci_state = ctrl_state[CTRL_PCI];

    clkstop_gate #(.WIDTH(N_CPU)) u_gate_cpu (
        .clk_src (clk_cpu),
        .rst_n   (rst_n),
        .en      (ctrl_en[CTRL_CPU]),
        .gclk    (cpu_out)
    );

    clkstop_gate #(.WIDTH(N_66)) u_gate_66 (
        .clk_src (clk_66),
        .rst_n   (rst_n),
        .en      (ctrl_en[CTRL_CPU]),
        .gclk    (c66_out)
    );

    clkstop_gate #(.WIDTH(N_PCI)) u_gate_pci (
        .clk_src (clk_pci),
        .rst_n   (rst_n),
        .en      (ctrl_en[CTRL_PCI]),
        .gclk    (pci_out)
    );
endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker
    import clkstop_pkg::*;
#(
    parameter int unsigned N_CPU = 4,
    parameter int unsigned N_66  = 4,
    parameter int unsigned N_PCI = 7
) (
    input logic             clk_cpu,
    input logic             clk_66,
    input logic             clk_pci,
    input logic             clk_pcif,
    input logic             rst_n,
    input logic             cpu_stop_n,
    input logic             pci_stop_n,
    input logic             force_sync,
    input grp_state_e       cpu_state,
    input grp_state_e       pci_state,
    input logic [N_CPU-1:0] cpu_out,
    input logic [N_66-1:0]  c66_out,
    input logic [N_PCI-1:0] pci_out
);
    p_cpu_halt_r1: assert property (@(posedge clk_pcif) disable iff (!rst_n)
        (!cpu_stop_n && !force_sync) |=> (cpu_state == GRP_HALT));

    p_pci_halt_r2: assert property (@(posedge clk_pcif) disable iff (!rst_n)
        (!pci_stop_n && !force_sync) |=> (pci_state == GRP_HALT));

    p_pci_indep_r3: assert property (@(posedge clk_pcif) disable iff (!rst_n)
        (!cpu_stop_n && pci_stop_n && !force_sync) |=> (pci_state == GRP_RUN));

    p_cpu_indep_r3: assert property (@(posedge clk_pcif) disable iff (!rst_n)
        (cpu_stop_n && !pci_stop_n && !force_sync) |=> (cpu_state == GRP_RUN));

    p_cpu_rest_low_r5: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ((cpu_state != GRP_RUN) && ($past(cpu_state) != GRP_RUN)) |-> (cpu_out == '0));

    p_cpu_full_run_r5: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        ((cpu_state == GRP_RUN) && ($past(cpu_state) == GRP_RUN)) |-> (cpu_out == '1));

    p_c66_rest_low_r1: assert property (@(negedge clk_66) disable iff (!rst_n)
        ((cpu_state != GRP_RUN) && ($past(cpu_state) != GRP_RUN)) |-> (c66_out == '0));

    p_pci_rest_low_r2: assert property (@(negedge clk_pci) disable iff (!rst_n)
        ((pci_state != GRP_RUN) && ($past(pci_state) != GRP_RUN)) |-> (pci_out == '0));

    p_force_off_r6: assert property (@(posedge clk_pcif) disable iff (!rst_n)
        force_sync |=> ((cpu_state == GRP_OFF) && (pci_state == GRP_OFF)));
endmodule

bind grp_clk_stopper clkstop_checker #(
    .N_CPU (N_CPU),
    .N_66  (N_66),
    .N_PCI (N_PCI)
) u_chk (
    .clk_cpu    (clk_cpu),
    .clk_66     (clk_66),
    .clk_pci    (clk_pci),
    .clk_pcif   (clk_pcif),
    .rst_n      (rst_n),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .force_sync (force_sync),
    .cpu_state  (cpu_state),
    .pci_state  (pci_state),
    .cpu_out    (cpu_out),
    .c66_out    (c66_out),
    .pci_out    (pci_out)
);

// File: tb/sim_grp_clk_stopper.sv
`timescale 1ns/1ps
module sim_grp_clk_stopper;
    localparam int N_CPU = 4;
    localparam int N_66  = 4;
    localparam int N_PCI = 7;

    logic clk_cpu = 1'b0, clk_66 = 1'b0, clk_pci = 1'b0, clk_pcif = 1'b0;
    logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, force_off = 1'b0;
    logic [N_CPU-1:0] cpu_out;
    logic [N_66-1:0]  c66_out;
    logic [N_PCI-1:0] pci_out;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference model: 0 off, 1 halt, 2 run
    int st_cpu = 0, st_pci = 0;
    bit f1 = 0, f2 = 0;
    bit eff_cpu = 0, eff_66 = 0, eff_pci = 0;
    int unsigned n = 0;

    grp_clk_stopper #(.N_CPU(N_CPU), .N_66(N_66), .N_PCI(N_PCI)) u0 (
        .clk_cpu(clk_cpu), .clk_66(clk_66), .clk_pci(clk_pci), .clk_pcif(clk_pcif),
        .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .force_off(force_off), .cpu_out(cpu_out), .c66_out(c66_out), .pci_out(pci_out)
    );

    function automatic int next_st(bit fs, bit req_n);
        if (fs) return 0;
        if (!req_n) return 1;
        return 2;
    endfunction

    // one half period of the 250 MHz CPU clock per step
    task automatic step(string tag);
        logic [N_CPU-1:0] e_cpu;
        logic [N_66-1:0]  e_66;
        logic [N_PCI-1:0] e_pci;
        n++;
        clk_cpu  = ~n[0];
        clk_66   = ~n[1];
        clk_pci  = ~n[2];
        clk_pcif = ~n[2];
        if (!rst_n) begin
            st_cpu = 0; st_pci = 0; f1 = 0; f2 = 0;
            eff_cpu = 0; eff_66 = 0; eff_pci = 0;
        end else begin
            if (n[2:0] == 3'd0) begin
                st_cpu = next_st(f2, cpu_stop_n);
                st_pci = next_st(f2, pci_stop_n);
                f2 = f1;
                f1 = force_off;
            end
            if (!clk_cpu) eff_cpu = (st_cpu == 2);
            if (!clk_66)  eff_66  = (st_cpu == 2);
            if (!clk_pci) eff_pci = (st_pci == 2);
        end
        e_cpu = (clk_cpu && eff_cpu) ? '1 : '0;
        e_66  = (clk_66  && eff_66)  ? '1 : '0;
        e_pci = (clk_pci && eff_pci) ? '1 : '0;
        #1;
        tests++;
        if (cpu_out !== e_cpu || c66_out !== e_66 || pci_out !== e_pci) begin
            fails++;
            $display("FAIL %s step %0d: cpu %b/%b c66 %b/%b pci %b/%b (actual/expected)",
                     tag, n, cpu_out, e_cpu, c66_out, e_66, pci_out, e_pci);
        end
        #1;
    endtask

    task automatic run(int k, string tag);
        for (int i = 0; i < k; i++) step(tag);
    endtask

    initial begin
        // R7: reset holds everything low
        run(6, "R7");
        rst_n = 1'b1;
        run(20, "R7");
        // R4: running baseline and latency on a mid-period request
        run(20, "R4");
        // R1 and R3: CPU stop only
        cpu_stop_n = 1'b0;
        run(40, "R1");
        // R5: clean restart
        cpu_stop_n = 1'b1;
        run(40, "R5");
        // R2 and R3: PCI stop only
        pci_stop_n = 1'b0;
        run(40, "R2");
        cpu_stop_n = 1'b0;
        run(40, "R3");
        pci_stop_n = 1'b1;
        run(40, "R3");
        cpu_stop_n = 1'b1;
        run(40, "R5");
        // R6: force overrides and resumes by request
        force_off = 1'b1;
        run(40, "R6");
        cpu_stop_n = 1'b0;
        run(16, "R6");
        force_off = 1'b0;
        run(40, "R6");
        cpu_stop_n = 1'b1;
        run(3, "R4");
        pci_stop_n = 1'b0;
        run(5, "R4");
        pci_stop_n = 1'b1;
        run(40, "R4");
        // R7: reset in the middle of operation
        rst_n = 1'b0;
        run(10, "R7");
        rst_n = 1'b1;
        run(30, "R7");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule